// File: doc/BRIEF.md
# Divider Tap Charge-Balancing PWM Steering

This block sits between the regulator of an isolated downstream converter and the two input switches of that converter. The converter takes its input charge either from the upper capacitor or from the lower capacitor of a capacitive divider. The divider is unequal: the upper capacitor carries two thirds of the bus and the lower capacitor carries one third. The regulator produces one PWM signal. The block hands each whole PWM period to exactly one of two gate outputs. The choice of output decides which capacitor gives up charge during that period, so the choice keeps the tap voltage near one third of the bus.

Three comparator flags describe the tap voltage:
- a high flag, set when the tap is above the upper edge of the tolerance band;
- a low flag, set when the tap is below the lower edge of the band;
- a target flag, set when the tap is above the exact one-third level.

While the tap is inside the band, the block alternates whole periods between the two outputs. When the tap leaves the band, the block sends every period to the side that pulls the tap back. It keeps doing so until the tap crosses the target level. All inputs pass through two-flop synchronisers, because the PWM arrives through an isolating coupler. The routing decision for a period is taken once, at the rising edge of the synchronised PWM.

Top module: `tsb_steer`

## Requirements
- R1: At no clock are both `gate_top` and `gate_bot` high. In each PWM period the output that was not chosen stays low for the whole period.
- R2: While no correction is active, successive PWM periods alternate between the two outputs. The first such period after reset goes to `gate_top`.
- R3: When `tap_high` is seen (tap above the band), every following period goes to `gate_bot`. This draws charge from the lower capacitor.
- R4: When `tap_low` is seen (tap below the band), every following period goes to `gate_top`. This draws charge from the upper capacitor.
- R5: A correction stays active until `tap_above_tgt` crosses the target, not only until the band flag clears. The encoding of `tap_above_tgt` is 1 when the tap is above one third of the bus and 0 when it is below. A correction started by `tap_high` ends when `tap_above_tgt` reads 0. A correction started by `tap_low` ends when `tap_above_tgt` reads 1.
- R6: The output chosen for a period is fixed at the rising edge of the synchronised PWM. A change of the comparator flags during the high time does not move the pulse to the other output.
- R7: If `tap_high` and `tap_low` are both seen at once, the block enters a fault state. Both outputs are then held low until reset, even after the flags clear.
- R8: A gate output follows `pwm_in` three clock edges later: two synchroniser stages plus one output register.
- R9: During and right after reset, both gate outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM from the downstream regulator, asynchronous to `clk` |
| tap_high | input | 1 | Tap above the upper band edge |
| tap_low | input | 1 | Tap below the lower band edge |
| tap_above_tgt | input | 1 | Tap above the exact one-third level |
| gate_top | output | 1 | Gate command of the switch fed by the upper capacitor |
| gate_bot | output | 1 | Gate command of the switch fed by the lower capacitor |

## Verification
The bench walks a sequence of periods that covers three cases:
- A correction outlives its band flag and is released only when the target flag flips. A design that released at the band edge would go back to alternating one period too early.
- After a correction, alternation resumes from where it stopped. A design that let corrected periods disturb the alternation phase would send the wrong output first.
- A flag changes in the middle of a period. A design that routes combinationally would split the pulse across both gates.

It also checks two further points:
- The fault state is sticky after the flags clear. A non-sticky design would resume pulsing.
- The exact three-edge latency. An extra or missing register would shift the first visible pulse edge.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

  typedef enum logic [1:0] {
    ST_BAL    = 2'd0,
    ST_TOPFAV = 2'd1,
    ST_BOTFAV = 2'd2,
    ST_FAULT  = 2'd3
  } steer_mode_e;

  // Returns {top, bot} for a period that starts in the given mode.
  function automatic logic [1:0] steer_pick(steer_mode_e mode, logic next_top);
    logic [1:0] r;
    case (mode)
      ST_BAL:    r = next_top ? 2'b10 : 2'b01;
      ST_TOPFAV: r = 2'b10;
      ST_BOTFAV: r = 2'b01;
      default:   r = 2'b00;
    endcase
    return r;
  endfunction

  // Next mode of the correction state machine.
  function automatic steer_mode_e steer_next(steer_mode_e mode, logic hi,
                                             logic lo, logic abv);
    steer_mode_e n;
    n = mode;
    if (hi && lo) begin
      n = ST_FAULT;
    end else begin
      case (mode)
        ST_BAL:    n = hi ? ST_BOTFAV : (lo ? ST_TOPFAV : ST_BAL);
        ST_BOTFAV: n = abv ? ST_BOTFAV : ST_BAL;
        ST_TOPFAV: n = abv ? ST_BAL : ST_TOPFAV;
        default:   n = ST_FAULT;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/tsb_sync.sv
module tsb_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tsb_mode.sv
module tsb_mode
  import tsb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hi,
  input  logic        lo,
  input  logic        abv,
  input  logic        period_start,
  output steer_mode_e mode_q,
  output logic        next_top_q,
  output logic        clash
);
  assign clash = hi & lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= ST_BAL;
      next_top_q <= 1'b1;
    end else begin
      mode_q <= steer_next(mode_q, hi, lo, abv);
      // Alternation phase advances only on balanced periods.
      if (period_start && mode_q == ST_BAL && !clash)
        next_top_q <= ~next_top_q;
    end
  end
endmodule

// File: rtl/tsb_route.sv
module tsb_route
  import tsb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwm_s,
  input  steer_mode_e mode_q,
  input  logic        next_top_q,
  input  logic        clash,
  output logic        period_start,
  output logic        route_top_q,
  output logic        route_bot_q,
  output logic        gate_top_q,
  output logic        gate_bot_q
);
  logic       pwm_d;
  logic       fault_now;
  logic [1:0] pick;
  logic       rt_nxt, rb_nxt;

  assign period_start = pwm_s & ~pwm_d;
  assign fault_now    = clash | (mode_q == ST_FAULT);
  assign pick         = fault_now ? 2'b00 : steer_pick(mode_q, next_top_q);
  assign rt_nxt       = period_start ? pick[1] : route_top_q;
  assign rb_nxt       = period_start ? pick[0] : route_bot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_d       <= 1'b0;
      route_top_q <= 1'b0;
      route_bot_q <= 1'b0;
      gate_top_q  <= 1'b0;
      gate_bot_q  <= 1'b0;
    end else begin
      pwm_d       <= pwm_s;
      route_top_q <= rt_nxt;
      route_bot_q <= rb_nxt;
      gate_top_q  <= pwm_s & rt_nxt & ~fault_now;
      gate_bot_q  <= pwm_s & rb_nxt & ~fault_now;
    end
  end
endmodule

// File: rtl/tsb_steer.sv
module tsb_steer
  import tsb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  input  logic tap_high,
  input  logic tap_low,
  input  logic tap_above_tgt,
  output logic gate_top,
  output logic gate_bot
);
  localparam int NIN = 4;

  logic [NIN-1:0] raw, syn;
  logic           pwm_s, hi_s, lo_s, abv_s;
  steer_mode_e    mode_q;
  logic           next_top_q, clash, period_start;
  logic           route_top_q, route_bot_q;
  logic           fault_q;

  assign raw = {pwm_in, tap_high, tap_low, tap_above_tgt};
  assign {pwm_s, hi_s, lo_s, abv_s} = syn;

  tsb_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  tsb_mode u_mode (
    .clk(clk), .rst_n(rst_n), .hi(hi_s), .lo(lo_s), .abv(abv_s),
    .period_start(period_start), .mode_q(mode_q),
    .next_top_q(next_top_q), .clash(clash)
  );

  tsb_route u_route (
    .clk(clk), .rst_n(rst_n), .pwm_s(pwm_s), .mode_q(mode_q),
    .next_top_q(next_top_q), .clash(clash), .period_start(period_start),
    .route_top_q(route_top_q), .route_bot_q(route_bot_q),
    .gate_top_q(gate_top), .gate_bot_q(gate_bot)
  );

  assign fault_q = (mode_q == ST_FAULT);
endmodule

// File: rtl/tsb_steer_chk.sv
module tsb_steer_chk
  import tsb_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        gate_top,
  input logic        gate_bot,
  input logic        period_start,
  input logic        route_top_q,
  input logic        route_bot_q,
  input logic        fault_q,
  input steer_mode_e mode_q
);
  a_r1_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_top && gate_bot));

  a_r1_top_follows_route: assert property (@(posedge clk) disable iff (!rst_n)
    gate_top |-> route_top_q);

  a_r1_bot_follows_route: assert property (@(posedge clk) disable iff (!rst_n)
    gate_bot |-> route_bot_q);

  a_r3_high_goes_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && mode_q == ST_BOTFAV) |=> (route_bot_q && !route_top_q));

  a_r4_low_goes_top: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && mode_q == ST_TOPFAV) |=> (route_top_q && !route_bot_q));

  a_r6_pulse_starts_at_period: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_top) || $rose(gate_bot)) |-> $past(period_start));

  a_r7_fault_silent: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> (!gate_top && !gate_bot));

  a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q);
endmodule

bind tsb_steer tsb_steer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .gate_top(gate_top), .gate_bot(gate_bot),
  .period_start(period_start), .route_top_q(route_top_q),
  .route_bot_q(route_bot_q), .fault_q(fault_q), .mode_q(mode_q)
);

// File: tb/tsb_steer_tb.sv
`timescale 1ns/1ps
module tsb_steer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_in = 1'b0, tap_high = 1'b0, tap_low = 1'b0, tap_above_tgt = 1'b0;
  logic gate_top, gate_bot;
  int   errors = 0;
  int   checks = 0;
  int   cycles = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  tsb_steer dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .tap_high(tap_high),
    .tap_low(tap_low), .tap_above_tgt(tap_above_tgt),
    .gate_top(gate_top), .gate_bot(gate_bot)
  );

  // {tap_high, tap_low, tap_above_tgt, expected top, expected bot}
  localparam logic [4:0] VEC [0:10] = '{
    5'b000_10,  // R2 first balanced period goes top
    5'b000_01,  // R2 alternate
    5'b000_10,  // R2 alternate
    5'b101_01,  // R3 tap high -> bottom
    5'b001_01,  // R5 band clear, still above target -> bottom
    5'b000_01,  // R5 released, alternation resumes (bottom next)
    5'b000_10,  // R2
    5'b010_10,  // R4 tap low -> top
    5'b000_10,  // R5 band clear, still below target -> top
    5'b001_01,  // R5 released, alternation resumes (bottom next)
    5'b001_10   // R2
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {top,bot} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic one_period(input string req, input logic h, input logic l,
                            input logic a, input logic [1:0] exp);
    tap_high = h; tap_low = l; tap_above_tgt = a;
    wait_neg(5);
    pwm_in = 1'b1;
    wait_neg(4);
    check(req, {gate_top, gate_bot}, exp);
    wait_neg(4);
    check({req, " R1 held"}, {gate_top, gate_bot}, exp);
    pwm_in = 1'b0;
    wait_neg(4);
    check({req, " R1 low after period"}, {gate_top, gate_bot}, 2'b00);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    wait_neg(3);
    check("R9 in reset", {gate_top, gate_bot}, 2'b00);
    rst_n = 1'b1;
    wait_neg(3);
    check("R9 after reset", {gate_top, gate_bot}, 2'b00);

    for (int k = 0; k < 11; k++)
      one_period($sformatf("vector %0d R2/R3/R4/R5", k),
                 VEC[k][4], VEC[k][3], VEC[k][2], VEC[k][1:0]);

    // R6: in balanced mode, next period goes bottom; tap_low mid-period must not move it.
    tap_high = 0; tap_low = 0; tap_above_tgt = 1;
    wait_neg(5);
    pwm_in = 1'b1;
    wait_neg(4);
    check("R6 start of period", {gate_top, gate_bot}, 2'b01);
    tap_low = 1'b1; tap_above_tgt = 1'b0;
    wait_neg(8);
    check("R6 held after flag change", {gate_top, gate_bot}, 2'b01);
    pwm_in = 1'b0;
    wait_neg(4);
    // Release correction, then balanced again: top next.
    one_period("R5/R2 after release", 1'b0, 1'b0, 1'b1, 2'b10);

    // R8: latency of three edges.
    tap_high = 0; tap_low = 0; tap_above_tgt = 1;
    wait_neg(5);
    pwm_in = 1'b1;
    wait_neg(2);
    check("R8 not yet after two edges", {gate_top, gate_bot}, 2'b00);
    wait_neg(1);
    check("R8 pulse after three edges", {gate_top, gate_bot}, 2'b01);
    wait_neg(3);
    pwm_in = 1'b0;
    wait_neg(2);
    check("R8 still high two edges after fall", {gate_top, gate_bot}, 2'b01);
    wait_neg(1);
    check("R8 low three edges after fall", {gate_top, gate_bot}, 2'b00);
    wait_neg(3);

    // R7: fault from both flags, sticky until reset.
    one_period("R7 both flags", 1'b1, 1'b1, 1'b0, 2'b00);
    one_period("R7 sticky after clear", 1'b0, 1'b0, 1'b0, 2'b00);
    rst_n = 1'b0;
    wait_neg(2);
    check("R9 reset again", {gate_top, gate_bot}, 2'b00);
    rst_n = 1'b1;
    one_period("R2/R7 recovered, first goes top", 1'b0, 1'b0, 1'b0, 2'b10);

    done = 1'b1;
    summary();
  end
endmodule